// File: doc/BRIEF.md
# Paged Memory Chip Address Translator

This block sits between a page register file and a bank of byte-wide memory chips. It takes a 12-bit page number and the 12 low bits of the bus address. From them it produces a 19-bit address inside one chip and an active-low select for one of 32 chips. The chips form 4 layers. Each layer holds 4 columns of chip pairs, and each pair has an even-byte row and an odd-byte row. The page bits are spread over the chip address, the column and the layer in a fixed, non-linear order. One layer bit is inverted so that page 000, the page seen after reset, lands on layer 2 and not on layer 1.

A compatibility input confines every access to layer 1 and to the lower quarter of each chip. Two static population straps fold the layer index when fewer layers are fitted. Both outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Page bits are named P4 (page[11], most significant) down to P15 (page[0]). Address bits are named A4 (ofs[11]) down to A15 (ofs[0]).

Top module: `xlat_top`

## Requirements
- R1: A synchronous active-high reset drives every chip select high and the chip address to zero. Outside reset, both outputs show the translation of the inputs sampled at the previous rising edge.
- R2: The chip address bits are, from bit 18 down to bit 0: page[9:4] (P6..P11), page[2] (P13), page[0] (P15), then ofs[11:1] (A4..A14).
- R3: Select index bit 0 is ofs[0]. An even byte (ofs[0]=0) selects the upper row (even index) and an odd byte selects the lower row (odd index).
- R4: Select index bits 2:1 are the column {page[3], page[1]} (P12, P14).
- R5: With both population straps set and compatibility off, the top page digit sets the layer. Digits 0-3 select layer 2, 4-7 layer 1, 8-B layer 4 and C-F layer 3. Select index bits 4:3 hold the layer number minus one.
- R6: With compatibility set, the layer is 1 whatever the top page digit. Chip address bits 18:17 (P6, P7) are forced to 0.
- R7: With both straps clear (one layer fitted), every page selects layer 1.
- R8: With only the low strap set (two layers), pages 800-FFF reach the same chips and addresses as pages 000-7FF.
- R9: With the high strap clear, select index bit 4 is cleared. With the low strap clear, index bit 3 is cleared. With both set, pages 800-BFF drive a layer-4 select (index 24-31); on a three-layer board these selects reach an empty socket.
- R10: With mem_req low, no chip select is asserted. With mem_req high, exactly one is asserted: chip_sel_n[index] goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory access strobe, active high |
| page | input | 12 | Page number, bit 11 = P4 |
| ofs | input | 12 | Low bus address bits, bit 11 = A4, bit 0 = byte row |
| compat | input | 1 | Compatibility mode: layer 1, lower quarter of chip |
| pop_lo | input | 1 | Strap: more than one layer fitted |
| pop_hi | input | 1 | Strap: more than two layers fitted |
| chip_addr | output | 19 | Registered address inside the selected chip |
| chip_sel_n | output | 32 | Registered active-low chip selects |

## Verification
The assertions assume that every input is settled and free of unknowns at each rising edge. They do not assume that the straps are static, because the straps feed only combinational logic ahead of the output register. The bench drives new inputs on the falling edge only, so each edge samples one stable vector. It switches the straps and the compatibility bit between directed phases and inside the mixed sweep, so the checks never rely on strap stability either.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_W    = 12;
  localparam int OFS_W     = 12;
  localparam int LAYER_W   = 2;
  localparam int COL_W     = 2;
  localparam int ROW_W     = 1;
  localparam int SEL_W     = LAYER_W + COL_W + ROW_W;
  localparam int NUM_CHIPS = 1 << SEL_W;
  localparam int PER_LAYER = NUM_CHIPS >> LAYER_W;
  localparam int HI_AW     = 6;                       // P6..P11
  localparam int MID_AW    = 2;                       // P13, P15
  localparam int CHIP_AW   = HI_AW + MID_AW + OFS_W - ROW_W;

  typedef struct packed {
    logic [LAYER_W-1:0] layer;
    logic [COL_W-1:0]   col;
    logic [ROW_W-1:0]   row;
    logic [CHIP_AW-1:0] addr;
  } xlat_fields_t;
endpackage

// File: rtl/xlat_page_split.sv
module xlat_page_split
  import xlat_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              compat,
  output xlat_fields_t      fields
);
  logic [HI_AW-1:0] hi_bits;
  logic [LAYER_W-1:0] layer_raw;

  always_comb begin
    // layer index = {P4, ~P5}; compatibility clears P4..P7 after the inversion
    layer_raw = {page[PAGE_W-1], ~page[PAGE_W-2]};
    hi_bits   = page[PAGE_W-3 -: HI_AW];
    if (compat) begin
      layer_raw = '0;
      hi_bits[HI_AW-1 -: 2] = 2'b00;
    end
    fields.layer = layer_raw;
    fields.col   = {page[3], page[1]};
    fields.row   = ofs[ROW_W-1:0];
    fields.addr  = {hi_bits, page[2], page[0], ofs[OFS_W-1:ROW_W]};
  end
endmodule

// File: rtl/xlat_layer_fold.sv
module xlat_layer_fold
  import xlat_pkg::*;
(
  input  logic [LAYER_W-1:0] layer_in,
  input  logic               pop_lo,
  input  logic               pop_hi,
  output logic [LAYER_W-1:0] layer_out
);
  logic [LAYER_W-1:0] keep;
  assign keep = {pop_hi, pop_lo};

  for (genvar b = 0; b < LAYER_W; b++) begin : g_fold
    assign layer_out[b] = layer_in[b] & keep[b];
  end
endmodule

// File: rtl/xlat_sel_decode.sv
module xlat_sel_decode
  import xlat_pkg::*;
(
  input  logic [SEL_W-1:0]     idx,
  input  logic                 en,
  output logic [NUM_CHIPS-1:0] sel_n
);
  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_sel
    assign sel_n[i] = ~(en && (idx == SEL_W'(i)));
  end
endmodule

// File: rtl/xlat_top.sv
module xlat_top
  import xlat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mem_req,
  input  logic [PAGE_W-1:0]    page,
  input  logic [OFS_W-1:0]     ofs,
  input  logic                 compat,
  input  logic                 pop_lo,
  input  logic                 pop_hi,
  output logic [CHIP_AW-1:0]   chip_addr,
  output logic [NUM_CHIPS-1:0] chip_sel_n
);
  xlat_fields_t          fields;
  logic [LAYER_W-1:0]    layer_f;
  logic [NUM_CHIPS-1:0]  sel_n_d;

  xlat_page_split u_split (
    .page   (page),
    .ofs    (ofs),
    .compat (compat),
    .fields (fields)
  );

  xlat_layer_fold u_fold (
    .layer_in  (fields.layer),
    .pop_lo    (pop_lo),
    .pop_hi    (pop_hi),
    .layer_out (layer_f)
  );

  xlat_sel_decode u_dec (
    .idx   ({layer_f, fields.col, fields.row}),
    .en    (mem_req),
    .sel_n (sel_n_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_addr  <= '0;
      chip_sel_n <= '1;
    end else begin
      chip_addr  <= fields.addr;
      chip_sel_n <= sel_n_d;
    end
  end
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
  import xlat_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 mem_req,
  input logic [OFS_W-1:0]     ofs,
  input logic                 compat,
  input logic                 pop_lo,
  input logic                 pop_hi,
  input logic [CHIP_AW-1:0]   chip_addr,
  input logic [NUM_CHIPS-1:0] chip_sel_n
);
  localparam logic [NUM_CHIPS-1:0] ODD_M  = {(NUM_CHIPS/2){2'b10}};
  localparam logic [NUM_CHIPS-1:0] EVEN_M = ~ODD_M;
  localparam logic [NUM_CHIPS-1:0] UP_M   = ~{{(NUM_CHIPS-PER_LAYER){1'b0}}, {PER_LAYER{1'b1}}};

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~chip_sel_n));
  assert_idle_none_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> (chip_sel_n == '1));
  assert_req_one_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> ($countones(~chip_sel_n) == 1));
  assert_even_row_R3: assert property (@(posedge clk) disable iff (rst)
    !ofs[0] |=> ((chip_sel_n & ODD_M) == ODD_M));
  assert_odd_row_R3: assert property (@(posedge clk) disable iff (rst)
    ofs[0] |=> ((chip_sel_n & EVEN_M) == EVEN_M));
  assert_low_addr_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chip_addr[OFS_W-2:0] == $past(ofs[OFS_W-1:1])));
  assert_compat_layer_R6: assert property (@(posedge clk) disable iff (rst)
    compat |=> (((chip_sel_n & UP_M) == UP_M) && (chip_addr[CHIP_AW-1 -: 2] == 2'b00)));
  assert_one_layer_R7: assert property (@(posedge clk) disable iff (rst)
    (!pop_lo && !pop_hi) |=> ((chip_sel_n & UP_M) == UP_M));
endmodule

bind xlat_top xlat_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .ofs        (ofs),
  .compat     (compat),
  .pop_lo     (pop_lo),
  .pop_hi     (pop_hi),
  .chip_addr  (chip_addr),
  .chip_sel_n (chip_sel_n)
);

// File: tb/sim_xlat_top.sv
module sim_xlat_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req = 1'b0;
  logic [11:0] page = '0;
  logic [11:0] ofs = '0;
  logic        compat = 1'b0;
  logic        pop_lo = 1'b1;
  logic        pop_hi = 1'b1;
  logic [18:0] chip_addr;
  logic [31:0] chip_sel_n;

  int checks = 0;
  int fails  = 0;
  bit pending = 0;
  bit done = 0;
  logic [18:0] exp_addr;
  logic [31:0] exp_sel;
  string       exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_top u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .page(page), .ofs(ofs),
    .compat(compat), .pop_lo(pop_lo), .pop_hi(pop_hi),
    .chip_addr(chip_addr), .chip_sel_n(chip_sel_n)
  );

  // layer number 1..4 from the requirements
  function automatic int ref_layer(input int pg, input bit cm, input bit lo, input bit hi);
    int dig, num, idx;
    dig = (pg >> 8) & 15;
    if (cm) num = 1;                      // R6
    else if (dig < 4) num = 2;            // R5
    else if (dig < 8) num = 1;
    else if (dig < 12) num = 4;
    else num = 3;
    idx = num - 1;
    if (!lo) idx = idx & 2;               // R9 low strap
    if (!hi) idx = idx & 1;               // R9 high strap
    return idx + 1;
  endfunction

  function automatic int ref_addr(input int pg, input int of, input bit cm);
    int hi6;
    hi6 = (pg >> 4) & 63;
    if (cm) hi6 = hi6 & 15;
    return (hi6 << 13) + (((pg >> 2) & 1) << 12) + ((pg & 1) << 11) + ((of >> 1) & 2047);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (chip_addr !== exp_addr || chip_sel_n !== exp_sel) begin
      fails++;
      $display("FAIL %s: addr=%h sel_n=%h expected addr=%h sel_n=%h",
               tag, chip_addr, chip_sel_n, exp_addr, exp_sel);
    end
  endtask

  task automatic step(input int pg, input int of, input bit rq, input bit cm,
                      input bit lo, input bit hi, input string tag);
    int lay, col, idx;
    @(negedge clk);
    if (pending) check(exp_tag);
    page = pg[11:0]; ofs = of[11:0]; mem_req = rq;
    compat = cm; pop_lo = lo; pop_hi = hi;
    lay = ref_layer(pg, cm, lo, hi);
    col = ((pg >> 3) & 1) * 2 + ((pg >> 1) & 1);        // R4
    idx = (lay - 1) * 8 + col * 2 + (of & 1);            // R3, R5
    exp_addr = 19'(ref_addr(pg, of, cm));
    exp_sel  = '1;
    if (rq) exp_sel[idx] = 1'b0;                         // R10
    exp_tag  = tag;
    pending  = 1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (chip_sel_n !== '1 || chip_addr !== '0) begin
      fails++;
      $display("FAIL R1: sel_n=%h addr=%h expected sel_n=ffffffff addr=0", chip_sel_n, chip_addr);
    end
    rst = 1'b0;
    // R1: one-cycle latency, page 000 reset page lands on layer 2
    step(12'h000, 12'h000, 1, 0, 1, 1, "R1");
    // R2: address composition
    step(12'h3F5, 12'hFFE, 1, 0, 1, 1, "R2");
    step(12'h2A4, 12'h556, 1, 0, 1, 1, "R2");
    // R3: byte row
    step(12'h123, 12'h001, 1, 0, 1, 1, "R3");
    step(12'h123, 12'h000, 1, 0, 1, 1, "R3");
    // R4: columns
    for (int c = 0; c < 4; c++)
      step(12'h100 | ((c >> 1) << 3) | ((c & 1) << 1), 12'h010, 1, 0, 1, 1, "R4");
    // R5: each top digit
    for (int d = 0; d < 16; d++)
      step((d << 8) | 12'h05A, 12'h204, 1, 0, 1, 1, "R5");
    // R6: compatibility
    for (int d = 0; d < 16; d += 3)
      step((d << 8) | 12'h0F3, 12'h7FF, 1, 1, 1, 1, "R6");
    // R7: one layer
    for (int d = 0; d < 16; d += 2)
      step((d << 8) | 12'h0C6, 12'h101, 1, 0, 0, 0, "R7");
    // R8: two layers, alias pairs compared through reference
    for (int d = 8; d < 16; d++) begin
      step((d << 8) | 12'h03C, 12'h0AA, 1, 0, 1, 0, "R8");
      step(((d - 8) << 8) | 12'h03C, 12'h0AA, 1, 0, 1, 0, "R8");
    end
    // R9: straps, layer-4 pages
    step(12'h8AB, 12'h333, 1, 0, 1, 1, "R9");
    step(12'hBFF, 12'h333, 1, 0, 1, 1, "R9");
    step(12'hC00, 12'h333, 1, 0, 0, 1, "R9");
    step(12'h800, 12'h333, 1, 0, 0, 1, "R9");
    // R10: idle strobe
    step(12'h9EE, 12'hABC, 0, 0, 1, 1, "R10");
    step(12'h9EE, 12'hABC, 1, 0, 1, 1, "R10");
    step(12'h000, 12'h000, 0, 1, 0, 0, "R10");
    // mixed sweep
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      step($urandom & 12'hFFF, $urandom & 12'hFFF, r[0] | r[1], r[2] & r[3],
           r[4], r[5], "R10");
    end
    @(negedge clk);
    if (pending) check(exp_tag);
    // R1: reset returns to idle
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (chip_sel_n !== '1 || chip_addr !== '0) begin
      fails++;
      $display("FAIL R1: sel_n=%h addr=%h expected sel_n=ffffffff addr=0", chip_sel_n, chip_addr);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule